// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two 32-bit operands by running a chain of identical one-bit steps. The result is formed in two registers. A 32-bit accumulator holds the upper half of the running product. A 32-bit Y register starts out holding the multiplier and fills up with the low product bits as they settle.

Each step does four things:
- It takes the lowest Y bit as the add decision.
- It moves Y down by one place, feeding the accumulator's lowest bit into the top of Y.
- It moves the accumulator down by one place, putting the true sign of the previous sum (N xor V) into its top bit.
- It adds either the multiplicand or zero.

The 32-bit sum sets four condition flags. A controller runs 32 such steps and then one more step with the addend forced to zero. After that, `{accumulator, Y}` is the 64-bit product. This holds exactly whenever both operands have a clear top bit.

The unit is driven by plain control pins:
- A `start` pulse while idle loads the operands and begins the run.
- `done` pulses once when the run ends.
- `product` and `flags` are continuous views of the registers, so there is no back-pressure. The result stays put until the next accepted `start`.
- With `step_mode` high, a step happens only in a cycle where `step_go` is high. This lets a test walk through the sequence one step at a time.

Top module: `mulstep_unit`

## Requirements
- R1: After reset, `busy`, `done`, `product` and `flags` are all zero.
- R2: A `start` seen while idle loads the multiplier into Y and clears the accumulator and all four flags. `busy` is high from the next cycle on, and `product` then reads `{32'h0, multiplier}`.
- R3: Every step captures the old Y bit 0 as the add decision. Y moves right by one, and the old accumulator bit 0 enters Y bit 31.
- R4: Every step moves the accumulator right by one and puts (N xor V) of the current flags into bit 31. The multiplicand is added when the captured bit is 1; otherwise zero is added.
- R5: The 32-bit sum of each step is the new accumulator. It also sets `flags`:
  - bit 3 is N, the sum's bit 31.
  - bit 2 is Z, set when the sum is zero.
  - bit 1 is V, set on two's-complement overflow of the addition.
  - bit 0 is C, the carry out of bit 31.
- R6: In free-running mode, a run is 32 steps plus a final step whose addend is forced to zero. The steps fall on the 33 clock edges after the start edge. The result `product = {accumulator, Y}` equals the unsigned product when both operands are below 2^31.
- R7: `done` is high for exactly one cycle, the cycle after the last step, with `busy` low. `product` and `flags` then hold until the next accepted `start`.
- R8: `start` has no effect while `busy` is high. The run continues with its original operands and ends at its original time.
- R9: With `step_mode` high, steps happen only in cycles where `step_go` is high. In other busy cycles `product` and `flags` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; honoured only when idle |
| multiplicand | input | 32 | Operand added on each enabled step |
| multiplier | input | 32 | Operand loaded into Y |
| step_mode | input | 1 | 1: step only when `step_go` is high |
| step_go | input | 1 | Step request used in single-step mode |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final step |
| product | output | 64 | `{accumulator, Y}` |
| flags | output | 4 | {N, Z, V, C} from the latest step |

## Verification
Full runs sweep a grid of operand pairs built from edge values and mixed bit patterns:
- Zero and one show the add decision and whether the Z flag comes out right.
- The largest positive operand exposes a wrong sign feed or carry handling in the upper half.
- Alternating-bit patterns catch a misplaced Y shift.

Single-step walks use a multiplicand with its top bit set. This forces the step sum to overflow and carry out, which makes V, C and the N-xor-V feed visible one step at a time. A mid-run start with different operands shows whether the busy lockout holds.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  // Flag word layout, bit 3 down to bit 0: N, Z, V, C
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } mstep_flags_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mstep_state_t;
endpackage

// File: rtl/mstep_alu.sv
module mstep_alu
  import mstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_q,
  input  logic             sign_feed,
  input  logic             add_en,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] acc_next,
  output mstep_flags_t     flags_next
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    shifted  = {sign_feed, acc_q[WIDTH-1:1]};
    addend   = add_en ? mcand : '0;
    wide_sum = {1'b0, shifted} + {1'b0, addend};
    acc_next = wide_sum[WIDTH-1:0];
    flags_next.n = wide_sum[WIDTH-1];
    flags_next.z = (wide_sum[WIDTH-1:0] == '0);
    flags_next.v = (shifted[WIDTH-1] == addend[WIDTH-1]) &&
                   (wide_sum[WIDTH-1] != shifted[WIDTH-1]);
    flags_next.c = wide_sum[WIDTH];
  end
endmodule

// File: rtl/mstep_ctrl.sv
module mstep_ctrl
  import mstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step_mode,
  input  logic step_go,
  output logic load,
  output logic step_en,
  output logic zero_op,
  output logic busy,
  output logic done
);
  localparam int LAST = WIDTH;
  localparam int CW   = $clog2(WIDTH + 2);

  mstep_state_t    state_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;

  always_comb begin
    busy    = (state_q == ST_RUN);
    load    = start && !busy;
    step_en = busy && (!step_mode || step_go);
    zero_op = (cnt_q == CW'(LAST));
    done    = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_en) begin
        if (zero_op) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: done lasts one cycle and never overlaps busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: step index never passes the final adjustment step
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST));
  // R8: a start during a run that is not ending leaves the run going
  p_start_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(step_en && zero_op)) |=> busy);
endmodule

// File: rtl/mstep_regs.sv
module mstep_regs
  import mstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_en,
  input  logic [WIDTH-1:0] mcand_in,
  input  logic [WIDTH-1:0] mplier_in,
  input  logic [WIDTH-1:0] acc_next,
  input  mstep_flags_t     flags_next,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] y_q,
  output logic [WIDTH-1:0] mcand_q,
  output mstep_flags_t     flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      y_q     <= '0;
      mcand_q <= '0;
      flags_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      y_q     <= mplier_in;
      mcand_q <= mcand_in;
      flags_q <= '0;
    end else if (step_en) begin
      acc_q   <= acc_next;
      y_q     <= {acc_q[0], y_q[WIDTH-1:1]};
      flags_q <= flags_next;
    end
  end

  // R2: a load clears the accumulator and flags
  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == '0) && (flags_q == '0));
  // R3: Y moves down and receives the old accumulator low bit
  p_y_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load) |=> (y_q[WIDTH-2:0] == $past(y_q[WIDTH-1:1])) &&
                           (y_q[WIDTH-1] == $past(acc_q[0])));
  // R8: the multiplicand copy changes only on an accepted start
  p_mcand_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));
  // R9: with no step and no load the state holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_en) |=> $stable(acc_q) && $stable(y_q) && $stable(flags_q));
endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
  import mstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  input  logic               step_mode,
  input  logic               step_go,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product,
  output logic [3:0]         flags
);
  logic             load, step_en, zero_op, add_en;
  logic [WIDTH-1:0] acc_q, y_q, mcand_q, acc_next;
  mstep_flags_t     flags_q, flags_next;

  mstep_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step_mode(step_mode),
    .step_go(step_go), .load(load), .step_en(step_en), .zero_op(zero_op),
    .busy(busy), .done(done)
  );

  // The final adjustment step forces the addend to zero
  assign add_en = y_q[0] && !zero_op;

  mstep_alu #(.WIDTH(WIDTH)) u_alu (
    .acc_q(acc_q), .sign_feed(flags_q.n ^ flags_q.v), .add_en(add_en),
    .mcand(mcand_q), .acc_next(acc_next), .flags_next(flags_next)
  );

  mstep_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .step_en(step_en),
    .mcand_in(multiplicand), .mplier_in(multiplier), .acc_next(acc_next),
    .flags_next(flags_next), .acc_q(acc_q), .y_q(y_q), .mcand_q(mcand_q),
    .flags_q(flags_q)
  );

  assign product = {acc_q, y_q};
  assign flags   = flags_q;

  // R7: after done the result holds until a new start
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(product) && $stable(flags));
  // R4: on an add step with the accumulator at zero and no sign feed, the sum is the multiplicand
  p_first_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && add_en && acc_q == '0 && !(flags_q.n ^ flags_q.v))
      |=> acc_q == $past(mcand_q));
endmodule

// File: tb/mulstep_unit_bench.sv
module mulstep_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic        step_mode = 1'b0;
  logic        step_go = 1'b0;
  logic        busy, done;
  logic [63:0] product;
  logic [3:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mulstep_unit u_mulstep_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .multiplicand(multiplicand),
    .multiplier(multiplier), .step_mode(step_mode), .step_go(step_go),
    .busy(busy), .done(done), .product(product), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic pulse_start(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    multiplicand = a; multiplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts the negedges until done shows; the start edge is already behind us
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic one_step();
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0003;
      3: return 32'h7fff_ffff;
      4: return 32'h4000_0000;
      5: return 32'h1234_5678;
      6: return 32'h0000_ffff;
      7: return 32'h5555_5555;
      8: return 32'h2aaa_aaab;
      default: return 32'h7ffe_0001;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cyc;
    logic [63:0] exp_p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 busy/done", {62'b0, busy, done}, 64'd0);
    check(product == 64'd0, "R1 product", product, 64'd0);
    check(flags == 4'd0, "R1 flags", {60'b0, flags}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 sweep over operand grid
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        pulse_start(pick(i), pick(j));
        check(busy, "R2 busy after start", {63'b0, busy}, 64'd1);
        wait_done(cyc);
        exp_p = {32'h0, pick(i)} * {32'h0, pick(j)};
        check(cyc == 33, "R6 run length", 64'(cyc), 64'd33);
        check(product == exp_p, "R6 product", product, exp_p);
        check(flags == {1'b0, exp_p[63:32] == 32'h0, 2'b00}, "R5 final flags",
              {60'b0, flags}, {60'b0, 1'b0, exp_p[63:32] == 32'h0, 2'b00});
        check(!busy, "R7 idle at done", {63'b0, busy}, 64'd0);
        @(negedge clk);
        check(!done, "R7 done one cycle", {63'b0, done}, 64'd0);
        check(product == exp_p, "R7 result held", product, exp_p);
      end
    end

    // R8 start during a run is ignored
    pulse_start(32'h0001_2345, 32'h0000_6789);
    repeat (5) @(negedge clk);
    multiplicand = 32'h7fff_0000; multiplier = 32'h7777_7777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(cyc == 27, "R8 original end time", 64'(cyc), 64'd27);
    exp_p = 64'h0001_2345 * 64'h0000_6789;
    check(product == exp_p, "R8 original operands", product, exp_p);

    // R9 single step walk, with R2 R3 R4 R5 step detail
    step_mode = 1'b1;
    pulse_start(32'h8000_0000, 32'h0000_0003);
    check(product == 64'h0000_0000_0000_0003, "R2 loaded", product, 64'h3);
    repeat (4) @(negedge clk);
    check(product == 64'h3 && flags == 4'd0 && busy, "R9 hold without step_go",
          product, 64'h3);
    one_step();
    check(product == 64'h8000_0000_0000_0001, "R3 R4 step1 regs", product,
          64'h8000_0000_0000_0001);
    check(flags == 4'b1000, "R5 step1 flags", {60'b0, flags}, 64'b1000);
    one_step();
    check(product == 64'h4000_0000_0000_0000, "R4 step2 sign feed add", product,
          64'h4000_0000_0000_0000);
    check(flags == 4'b0011, "R5 step2 overflow carry", {60'b0, flags}, 64'b0011);
    one_step();
    check(product == 64'ha000_0000_0000_0000, "R4 step3 no add", product,
          64'ha000_0000_0000_0000);
    check(flags == 4'b1000, "R5 step3 flags", {60'b0, flags}, 64'b1000);
    repeat (3) @(negedge clk);
    check(product == 64'ha000_0000_0000_0000, "R9 hold between steps", product,
          64'ha000_0000_0000_0000);
    for (int k = 0; k < 29; k++) one_step();
    check(busy && !done, "R9 not finished after 32 steps", {62'b0, busy, done}, 64'd2);
    one_step();
    check(done && !busy, "R9 done after step 33", {62'b0, busy, done}, 64'd1);
    step_mode = 1'b0;

    // R2 reload clears flags from a run with nonzero state
    pulse_start(32'h0000_0000, 32'h0000_0005);
    check(product == 64'h5 && flags == 4'd0, "R2 reload clears", product, 64'h5);
    wait_done(cyc);
    check(product == 64'd0 && flags == 4'b0100, "R6 zero multiplicand", product, 64'd0);

    summary();
  end
endmodule